// File: doc/BRIEF.md
# Keyed Reset Pulse Shaper

The block turns a one-cycle watchdog expiry request into a reset pulse on an external pin. The pulse lasts a programmable number of microseconds. The time base is a one-cycle strobe that arrives once per microsecond. A single 32-bit configuration word holds the pulse width in its low field and two mode bits in its top bits. One mode bit sets the asserted polarity and the other sets the drive style, push-pull or open-drain. The block produces the pin data value and the pin output-enable. The pad cell itself sits outside the block.

The mode bits are protected against stray writes. They change only when the top byte of a write carries one of four key codes. A write with any other top byte still updates the width field and leaves both modes as they were. Reads return the stored width and the two mode bits in the positions given below.

The pulse timing is controlled by a three-state machine.
- `ST_IDLE` means no pulse is in progress.
- `ST_HOLD` means more than one tick of the pulse remains.
- `ST_FINAL` means the last tick interval of the pulse is running.

The transitions are these.
- *launch*: an expiry request arrives in any state. The machine moves to `ST_HOLD` with the count loaded from the width, or to `ST_FINAL` when the width is zero.
- *count*: a tick arrives in `ST_HOLD` while the count is above 1. The count is decremented.
- *last*: a tick arrives in `ST_HOLD` while the count is 1. The machine moves to `ST_FINAL`.
- *finish*: a tick arrives in `ST_FINAL`. The machine moves to `ST_IDLE`.

Top module: `rst_pulse_shaper`

## Requirements
- R1: After reset, the configuration word reads 0x000000FF, which is width 255, active-low and open-drain. The pin is idle, so `pin_oe` is 0 and `pin_out` is 0.
- R2: Every write stores `wr_data[WIDTH_BITS-1:0]` as the width. Read bits 29 down to `WIDTH_BITS` are always 0.
- R3: A write whose top byte (bits 31:24) is 0xA5 selects active-high polarity. A top byte of 0x5A selects active-low polarity.
- R4: A write whose top byte is 0xA8 selects push-pull drive. A top byte of 0x8A selects open-drain drive.
- R5: A write with any other top byte leaves both polarity and drive unchanged. The width is still updated, and key writes also update the width.
- R6: Read bit 31 is 1 when the polarity is active-high. Read bit 30 is 1 when the drive is push-pull.
- R7: The pulse starts when `expire` is sampled high at a clock edge, using a stored width N. The pulse is asserted from that edge until the edge that samples the (N+1)th `tick_1us` strike after it. A tick in the same cycle as `expire` is not counted.
- R8: If `expire` arrives while a pulse is in progress, the remaining duration restarts at N+1 ticks.
- R9: In push-pull mode, `pin_oe` is 1 at all times. `pin_out` equals the asserted level while a pulse is in progress and the inverse of that level otherwise.
- R10: In open-drain mode, `pin_out` is always 0. `pin_oe` is 1 exactly when the pin level should be low. For active-high polarity this means the pin is released during the pulse.
- R11: The width is captured when `expire` is sampled. A write during a pulse does not change that pulse and applies to the next pulse. A write in the same cycle as `expire` applies to the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle strobe, once per microsecond |
| expire | input | 1 | One-cycle watchdog expiry request |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Configuration write data |
| rd_data | output | 32 | Configuration read value |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output-enable |

## Verification
The main risk is a wrong count or a wrong state in the pulse machine. Either fault shows up as a pin edge that lands one tick early or one tick late. It can also leave the pin asserted forever. The fault becomes visible at the first tick where the end of the pulse is due.

A corrupted mode bit flips the pin level or the output-enable in the cycle after the write. The effect appears even when no pulse is running. It also shows up at once in bits 31 and 30 of the read value.

Because the pins and the read value are compared against a reference model on every clock, each of these faults is caught within one cycle of the point where it first becomes visible.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FINAL = 2'd2
    } pulse_state_t;

    localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
    localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
    localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
    localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

    localparam int POL_BIT   = 31;
    localparam int DRIVE_BIT = 30;

endpackage

// File: rtl/rps_cfg_reg.sv
module rps_cfg_reg
    import rps_pkg::*;
#(
    parameter int WIDTH_BITS = 20,
    parameter int DEF_WIDTH  = 255
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    output logic [WIDTH_BITS-1:0] width_q,
    output logic                  act_high,
    output logic                  push_pull,
    output logic [31:0]           rd_data
);

    localparam int PAD_BITS = 30 - WIDTH_BITS;

    logic [7:0] key_byte;
    logic       pol_d;
    logic       drv_d;

    assign key_byte = wr_data[31:24];

    always_comb begin
        pol_d = act_high;
        drv_d = push_pull;
        if (wr_en) begin
            unique case (key_byte)
                KEY_ACT_HIGH:  pol_d = 1'b1;
                KEY_ACT_LOW:   pol_d = 1'b0;
                KEY_PUSH_PULL: drv_d = 1'b1;
                KEY_OPEN_DRN:  drv_d = 1'b0;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q   <= WIDTH_BITS'(DEF_WIDTH);
            act_high  <= 1'b0;
            push_pull <= 1'b0;
        end else begin
            act_high  <= pol_d;
            push_pull <= drv_d;
            if (wr_en) begin
                width_q <= wr_data[WIDTH_BITS-1:0];
            end
        end
    end

    assign rd_data = {act_high, push_pull, {PAD_BITS{1'b0}}, width_q};

    assert_mode_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte != KEY_ACT_HIGH && key_byte != KEY_ACT_LOW &&
         key_byte != KEY_PUSH_PULL && key_byte != KEY_OPEN_DRN)
        |=> ($stable(act_high) && $stable(push_pull)));

    assert_key_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte == KEY_ACT_HIGH) |=> rd_data[POL_BIT]);

    assert_key_pushpull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte == KEY_PUSH_PULL) |=> rd_data[DRIVE_BIT]);

    assert_width_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (width_q == $past(wr_data[WIDTH_BITS-1:0])));

endmodule

// File: rtl/rps_pulse_fsm.sv
module rps_pulse_fsm
    import rps_pkg::*;
#(
    parameter int WIDTH_BITS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trigger,
    input  logic                  tick,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic                  asserted
);

    pulse_state_t          st_q, st_d;
    logic [WIDTH_BITS-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (trigger) begin
            if (width_i == '0) begin
                st_d  = ST_FINAL;
                cnt_d = '0;
            end else begin
                st_d  = ST_HOLD;
                cnt_d = width_i;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_HOLD: begin
                    if (tick) begin
                        if (cnt_q == WIDTH_BITS'(1)) begin
                            st_d  = ST_FINAL;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q - WIDTH_BITS'(1);
                        end
                    end
                end
                ST_FINAL: begin
                    if (tick) begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        asserted = (st_q != ST_IDLE);
    end

    assert_trigger_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> asserted);

    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!asserted && !trigger) |=> !asserted);

    assert_no_early_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (asserted && !tick && !trigger) |=> asserted);

    assert_restart_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && width_i != '0) |=> (st_q == ST_HOLD && cnt_q != '0));

endmodule

// File: rtl/rps_pad_drive.sv
module rps_pad_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic asserted,
    input  logic act_high,
    input  logic push_pull,
    output logic pin_out,
    output logic pin_oe
);

    logic level;

    always_comb begin
        level = asserted ? act_high : !act_high;
        if (push_pull) begin
            pin_out = level;
            pin_oe  = 1'b1;
        end else begin
            pin_out = 1'b0;
            pin_oe  = !level;
        end
    end

    assert_od_pulls_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && pin_oe) |-> (asserted != act_high));

    assert_pp_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_pull && asserted) |-> (pin_out == act_high && pin_oe));

endmodule

// File: rtl/rst_pulse_shaper.sv
module rst_pulse_shaper #(
    parameter int WIDTH_BITS = 20,
    parameter int DEF_WIDTH  = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1us,
    input  logic        expire,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pin_out,
    output logic        pin_oe
);

    logic [WIDTH_BITS-1:0] width_q;
    logic                  act_high;
    logic                  push_pull;
    logic                  asserted;

    rps_cfg_reg #(
        .WIDTH_BITS(WIDTH_BITS),
        .DEF_WIDTH (DEF_WIDTH)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .width_q  (width_q),
        .act_high (act_high),
        .push_pull(push_pull),
        .rd_data  (rd_data)
    );

    rps_pulse_fsm #(
        .WIDTH_BITS(WIDTH_BITS)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (expire),
        .tick    (tick_1us),
        .width_i (width_q),
        .asserted(asserted)
    );

    rps_pad_drive pad_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .asserted (asserted),
        .act_high (act_high),
        .push_pull(push_pull),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: tb/rst_pulse_shaper_tb.sv
module rst_pulse_shaper_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;
    localparam int TICK_DIV   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        expire = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pin_out;
    logic        pin_oe;

    int checks = 0;
    int errors = 0;
    int phase = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_width = 255;
    int m_ah = 0;
    int m_pp = 0;
    int m_rem = 0;

    rst_pulse_shaper dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_1us(tick_1us),
        .expire  (expire),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rd();
        return {m_ah[0], m_pp[0], 10'b0, m_width[19:0]};
    endfunction

    task automatic compare_all();
        logic lvl;
        logic e_out;
        logic e_oe;
        lvl = (m_rem > 0) ? m_ah[0] : !m_ah[0];
        if (m_pp != 0) begin
            e_out = lvl;
            e_oe  = 1'b1;
        end else begin
            e_out = 1'b0;
            e_oe  = !lvl;
        end
        check({cur_req, " rd"}, rd_data, m_rd());
        check({cur_req, " pin"}, {30'b0, pin_oe, pin_out}, {30'b0, e_oe, e_out});
    endtask

    task automatic step(input logic exp_i, input logic we, input logic [31:0] d);
        expire   = exp_i;
        wr_en    = we;
        wr_data  = d;
        tick_1us = (phase == 0);
        phase    = (phase + 1) % TICK_DIV;
        @(posedge clk);
        if (exp_i) m_rem = m_width + 1;
        else if (tick_1us && m_rem > 0) m_rem = m_rem - 1;
        if (we) begin
            m_width = int'(d[W-1:0]);
            case (d[31:24])
                8'hA5: m_ah = 1;
                8'h5A: m_ah = 0;
                8'hA8: m_pp = 1;
                8'h8A: m_pp = 0;
                default: ;
            endcase
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [31:0] d);
        step(1'b0, 1'b1, d);
    endtask

    task automatic fire();
        step(1'b1, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 reset rd", rd_data, 32'h0000_00FF);
        check("R1 reset pins", {30'b0, pin_oe, pin_out}, 32'h0);

        cur_req = "R2";
        wr(32'h0000_0003);
        check("R2 width", rd_data, 32'h0000_0003);
        cur_req = "R5";
        wr(32'hFFFF_FFFF);
        check("R5 R2 other key keeps mode, upper zero", rd_data, 32'h000F_FFFF);
        wr(32'h1200_0002);
        check("R5 width via non-key", rd_data, 32'h0000_0002);

        cur_req = "R10";
        fire();
        idle(12);

        cur_req = "R3";
        wr(32'hA500_0002);
        check("R3 R6 active-high bit31", rd_data, 32'h8000_0002);
        cur_req = "R10";
        check("R10 active-high OD idle drives low", {30'b0, pin_oe, pin_out}, 32'h2);
        fire();
        check("R10 active-high OD releases", {30'b0, pin_oe, pin_out}, 32'h0);
        idle(12);

        cur_req = "R4";
        wr(32'hA800_0004);
        check("R4 R6 push-pull bit30", rd_data, 32'hC000_0004);
        cur_req = "R9";
        fire();
        check("R9 pp asserted high", {30'b0, pin_oe, pin_out}, 32'h3);
        cur_req = "R7";
        idle(20);

        cur_req = "R8";
        fire();
        idle(5);
        fire();
        idle(20);

        cur_req = "R11";
        fire();
        wr(32'h0000_0001);
        idle(20);
        fire();
        idle(10);
        step(1'b1, 1'b1, 32'h0000_0005);
        idle(25);

        cur_req = "R3";
        wr(32'h5A00_0000);
        check("R3 active-low", rd_data[31:30], 2'b01);
        cur_req = "R7";
        for (int k = 0; k < TICK_DIV; k++) begin
            fire();
            idle(6);
        end

        cur_req = "R4";
        wr(32'h8A00_0002);
        check("R4 open-drain", rd_data, 32'h0000_0002);
        cur_req = "R10";
        fire();
        check("R10 active-low OD drives low", {30'b0, pin_oe, pin_out}, 32'h2);
        idle(12);
        check("R10 idle released", {30'b0, pin_oe, pin_out}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule